// File: doc/BRIEF.md
# Sixteen-Pin Flag Port with Write-One Aliases and Pin Events

The block is a general-purpose flag port with sixteen bidirectional pins. Every pin has its own direction bit. Each output flag can be changed in one of two ways: through write-one aliases that raise, lower or invert the chosen bits and leave all other bits alone, or through a direct data write that loads every flag at once. Reading the data address returns the present sense of each pin. An output pin reports the value it drives. An input pin reports its pad after a two-flop synchronizer.

Each input pin can act as an interrupt source.

- **Sensitivity.** A sensitivity register makes the pin either level-sensitive or edge-sensitive. A second register chooses, for edge pins, between rising edges only and both edges.
- **Latching.** Edge events are held until software writes a one for that pin to the lower-alias address.
- **Level events.** A level event follows the synchronized pin.
- **Mask.** Masks are changed through their own set and clear aliases.
- **Interrupt output.** A single registered interrupt output gathers every masked event.

Top module: `gpio_flag_ctrl`

## Requirements
- R1: After reset every pin is an input (`pad_oe_o` = 0), all flags, masks, sensitivity bits and pending events are 0, and `irq_o` is 0.
- R2: Address 4 holds the direction register, where 1 makes a pin an output. The register drives `pad_oe_o` from the clock edge that writes it, and it reads back unchanged.
- R3: A write to address 1 sets every flag whose data bit is 1 and leaves the other flags unchanged.
- R4: A write to address 2 clears every flag whose data bit is 1 and leaves the other flags unchanged.
- R5: A write to address 3 inverts every flag whose data bit is 1. The flags drive `pad_o`.
- R6: A write to address 0 loads all flags. A read of address 0 returns the drive value for output pins and the synchronized pad for input pins. A pad change shows up after two clock edges.
- R7: A write to address 5 sets mask bits where the data is 1. A write to address 6 clears mask bits where the data is 1. A read of address 5 or 6 returns the mask.
- R8: In level mode (sensitivity bit at address 7 is 0), a masked input pin that is held high raises `irq_o` three edges after the pad rises. `irq_o` drops three edges after the pad falls.
- R9: In edge mode (bit at address 7 is 1) with the both-edges bit at address 8 equal to 0, a rising pad latches an event. The event persists after the pad falls. A falling pad latches nothing.
- R10: With the both-edges bit at 1, a falling pad also latches an event.
- R11: A write to address 2 clears latched edge events for the pins whose data bit is 1. Pending events read at address 9. If a new edge arrives in the same cycle as the clear, the new edge wins.
- R12: `irq_o` is the OR of (pending & mask), registered one cycle. Output pins never generate events. Unmasked events are visible at address 9 but do not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from `addr_i` |
| pad_i | input | 16 | Pin input levels (asynchronous) |
| pad_o | output | 16 | Pin drive values |
| pad_oe_o | output | 16 | Pin output enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `pad_i` is a real asynchronous level with no X after reset. They also assume that the bus presents a stable address and data through each clock edge on which `req_i` is high. The stimulus changes the pads and all bus fields only on falling clock edges. It holds each pad level for at least four edges, so that each level is synchronized and its edge is detected before the next change. Reads are sampled a short time after the address settles, away from rising edges.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;
  localparam int unsigned REG_ADDR_W = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_DATA  = 4'd0,
    A_SET   = 4'd1,
    A_CLR   = 4'd2,
    A_TGL   = 4'd3,
    A_DIR   = 4'd4,
    A_MSET  = 4'd5,
    A_MCLR  = 4'd6,
    A_SENSE = 4'd7,
    A_BOTH  = 4'd8,
    A_PEND  = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/gpio_flag_sync.sv
module gpio_flag_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_flag_regs.sv
module gpio_flag_regs
  import gpio_flag_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0]   sync_i,
  input  logic [NUM_PINS-1:0]   pend_i,
  output logic [NUM_PINS-1:0]   rdata_o,
  output logic [NUM_PINS-1:0]   out_o,
  output logic [NUM_PINS-1:0]   dir_o,
  output logic [NUM_PINS-1:0]   mask_o,
  output logic [NUM_PINS-1:0]   sense_o,
  output logic [NUM_PINS-1:0]   both_o,
  output logic [NUM_PINS-1:0]   clr_o
);
  reg_addr_e addr;
  logic      wr;
  logic [NUM_PINS-1:0] out_q, dir_q, mask_q, sense_q, both_q;
  logic [NUM_PINS-1:0] out_d, mask_d;

  assign addr = reg_addr_e'(addr_i);
  assign wr   = req_i & we_i;

  always_comb begin
    out_d  = out_q;
    mask_d = mask_q;
    if (wr) begin
      unique case (addr)
        A_DATA:  out_d  = wdata_i;
        A_SET:   out_d  = out_q | wdata_i;
        A_CLR:   out_d  = out_q & ~wdata_i;
        A_TGL:   out_d  = out_q ^ wdata_i;
        A_MSET:  mask_d = mask_q | wdata_i;
        A_MCLR:  mask_d = mask_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
    end else begin
      out_q  <= out_d;
      mask_q <= mask_d;
      if (wr && addr == A_DIR)   dir_q   <= wdata_i;
      if (wr && addr == A_SENSE) sense_q <= wdata_i;
      if (wr && addr == A_BOTH)  both_q  <= wdata_i;
    end
  end

  // clear alias also drops latched edge events
  assign clr_o = (wr && addr == A_CLR) ? wdata_i : '0;

  always_comb begin
    unique case (addr)
      A_DATA:         rdata_o = (dir_q & out_q) | (~dir_q & sync_i);
      A_DIR:          rdata_o = dir_q;
      A_MSET, A_MCLR: rdata_o = mask_q;
      A_SENSE:        rdata_o = sense_q;
      A_BOTH:         rdata_o = both_q;
      A_PEND:         rdata_o = pend_i;
      default:        rdata_o = '0;
    endcase
  end

  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign mask_o  = mask_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;

  // R3
  set_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_SET) |=> ((out_q & $past(wdata_i)) == $past(wdata_i)
      && (out_q & ~$past(wdata_i)) == ($past(out_q) & ~$past(wdata_i))));
  // R4
  clr_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_CLR) |=> ((out_q & $past(wdata_i)) == '0
      && (out_q & ~$past(wdata_i)) == ($past(out_q) & ~$past(wdata_i))));
  // R5
  tgl_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_TGL) |=> (out_q == ($past(out_q) ^ $past(wdata_i))));
  // R7
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_MSET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R7
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && (addr_i == A_MSET || addr_i == A_MCLR)) |=> $stable(mask_q));
endmodule

// File: rtl/gpio_flag_evt.sv
module gpio_flag_evt #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] prev_q, latch_q, hit, event_v;
  logic                irq_q;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic rise, fall;
    assign rise   = sync_i[g] & ~prev_q[g];
    assign fall   = ~sync_i[g] & prev_q[g];
    assign hit[g] = sense_i[g] & ~dir_i[g] & (rise | (both_i[g] & fall));
    assign event_v[g] = ~dir_i[g] & (sense_i[g] ? latch_q[g] : sync_i[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      latch_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      prev_q  <= sync_i;
      latch_q <= (latch_q & ~clr_i) | hit;  // new edge beats clear
      irq_q   <= |(event_v & mask_i);
    end
  end

  assign pend_o = event_v;
  assign irq_o  = irq_q;

  // R12
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> !irq_o);
  // R12
  out_pin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & dir_i) == '0);
  // R11
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((latch_q & $past(latch_q)) == $past(latch_q)));
endmodule

// File: rtl/gpio_flag_ctrl.sv
module gpio_flag_ctrl
  import gpio_flag_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  output logic [NUM_PINS-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0]   pad_i,
  output logic [NUM_PINS-1:0]   pad_o,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic                  irq_o
);
  logic [NUM_PINS-1:0] sync, pend, out, dir, mask, sense, both, clr;

  gpio_flag_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(sync)
  );

  gpio_flag_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .sync_i(sync), .pend_i(pend),
    .rdata_o(rdata_o), .out_o(out), .dir_o(dir), .mask_o(mask),
    .sense_o(sense), .both_o(both), .clr_o(clr)
  );

  gpio_flag_evt #(.NUM_PINS(NUM_PINS)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync), .dir_i(dir),
    .mask_i(mask), .sense_i(sense), .both_i(both), .clr_i(clr),
    .pend_o(pend), .irq_o(irq_o)
  );

  assign pad_o    = out;
  assign pad_oe_o = dir;

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_DIR) |=> (pad_oe_o == $past(wdata_i)));
endmodule

// File: tb/tb_gpio_flag_ctrl.sv
module tb_gpio_flag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpio_flag_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  a;
    logic [15:0] d;
    logic [7:0]  req_no;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd4, 16'h00FF, 8'd2},
    '{1'b0, 4'd4, 16'h00FF, 8'd2},   // R2 readback
    '{1'b1, 4'd0, 16'hA5A5, 8'd6},
    '{1'b0, 4'd0, 16'h00A5, 8'd6},   // R6 inputs show pad 0
    '{1'b1, 4'd1, 16'h0050, 8'd3},
    '{1'b0, 4'd0, 16'h00F5, 8'd3},   // R3
    '{1'b1, 4'd2, 16'h0081, 8'd4},
    '{1'b0, 4'd0, 16'h0074, 8'd4},   // R4
    '{1'b1, 4'd3, 16'h00FF, 8'd5},
    '{1'b0, 4'd0, 16'h008B, 8'd5},   // R5
    '{1'b1, 4'd5, 16'hF00F, 8'd7},
    '{1'b1, 4'd6, 16'h000F, 8'd7},
    '{1'b0, 4'd5, 16'hF000, 8'd7},   // R7
    '{1'b0, 4'd6, 16'hF000, 8'd7},   // R7
    '{1'b1, 4'd7, 16'h1234, 8'd9},
    '{1'b0, 4'd7, 16'h1234, 8'd9}    // R9 sensitivity readback
  };

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #2 d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 oe", pad_oe, 16'h0);
    chk("R1 pad_o", pad_out, 16'h0);
    rd(4'd5, v); chk("R1 mask", v, 16'h0);
    rd(4'd9, v); chk("R1 pend", v, 16'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a, v);
        chk($sformatf("R%0d vec%0d", VEC[i].req_no, i), v, VEC[i].d);
      end
    end
    // R2 R5 at pins
    chk("R2 oe", pad_oe, 16'h00FF);
    chk("R5 pad_o", pad_out, 16'hA58B);
    // R6 input pad visible after sync
    @(negedge clk); pad_in = 16'h3C00;
    cyc(3);
    rd(4'd0, v); chk("R6 status", v, 16'h3C8B);
    @(negedge clk); pad_in = 16'h0000;
    cyc(4);

    wr(4'd4, 16'h0000);
    wr(4'd7, 16'h0000);
    wr(4'd6, 16'hFFFF);
    wr(4'd5, 16'h0001);
    // R8 level
    @(negedge clk); pad_in[0] = 1'b1;
    cyc(4); chk("R8 level high", {15'd0, irq}, 16'h1);
    @(negedge clk); pad_in[0] = 1'b0;
    cyc(4); chk("R8 level low", {15'd0, irq}, 16'h0);

    // R9 rising edge on pin1
    wr(4'd7, 16'h0002);
    wr(4'd5, 16'h0002);
    @(negedge clk); pad_in[1] = 1'b1;
    cyc(4); chk("R9 rise", {15'd0, irq}, 16'h1);
    @(negedge clk); pad_in[1] = 1'b0;
    cyc(4); chk("R9 persists", {15'd0, irq}, 16'h1);
    rd(4'd9, v); chk("R11 pend", v, 16'h0002);
    wr(4'd2, 16'h0002);
    cyc(2); chk("R11 cleared irq", {15'd0, irq}, 16'h0);
    rd(4'd9, v); chk("R11 cleared pend", v, 16'h0000);
    // R9 falling ignored
    @(negedge clk); pad_in[1] = 1'b1;
    cyc(4);
    wr(4'd2, 16'h0002);
    @(negedge clk); pad_in[1] = 1'b0;
    cyc(4); chk("R9 fall ignored", {15'd0, irq}, 16'h0);
    // R10 both edges
    wr(4'd8, 16'h0002);
    @(negedge clk); pad_in[1] = 1'b1;
    cyc(4);
    wr(4'd2, 16'h0002);
    cyc(2); chk("R10 cleared", {15'd0, irq}, 16'h0);
    @(negedge clk); pad_in[1] = 1'b0;
    cyc(4); chk("R10 fall", {15'd0, irq}, 16'h1);
    wr(4'd2, 16'h0002);
    cyc(2);

    // R12 output pin and unmasked pin
    wr(4'd4, 16'h0004);
    wr(4'd5, 16'h0004);
    @(negedge clk); pad_in[2] = 1'b1; pad_in[3] = 1'b1;
    cyc(4); chk("R12 irq", {15'd0, irq}, 16'h0);
    rd(4'd9, v); chk("R12 pend", v, 16'h0008);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule